// File: doc/BRIEF.md
# Streaming Sobel Edge Filter

This block accepts a single-channel image, one 8-bit pixel per strobe in raster order, at whatever sparse and uneven rate an upstream serial receiver delivers it. Two one-row line buffers and a 3x3 register window hold the neighbourhood of a pixel. For each pixel the block computes the Sobel gradient magnitude and issues it as a one-cycle write, with its linear address, to a frame RAM that the display side reads later.

Every strobe moves the pipeline forward by one pixel. The window centre lags the newest pixel by one row plus one pixel. Each strobe from the (width+2)-th pixel of a frame onward therefore produces the result for the pixel that lies width+1 positions earlier. When the last pixel of a frame has arrived, the block writes the remaining border results by itself on consecutive cycles. The whole frame RAM is then written exactly once per frame. A frame-start pulse discards any partial frame and rewinds the block.

Top module: `sobel_edge_stream`

## Requirements
- R1: After reset, wr_en, wr_addr and wr_data are all 0. Reset has the same effect as a frame start.
- R2: Only a cycle with pix_valid high moves the line buffers, the window and the position counters. With no strobe there are no writes, and the results that follow are unchanged.
- R3: An interior result is min(255, |Gx|+|Gy|). Gx weights the column to the right of the centre with +1,+2,+1 from top to bottom and the column to the left with -1,-2,-1. Gy weights the row below with +1,+2,+1 from left to right and the row above with -1,-2,-1.
- R4: A pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 is written as 0.
- R5: Every frame produces exactly IMG_W*IMG_H writes. Each goes to address row*IMG_W+col, the addresses rise from 0 in raster order, and each address is written once.
- R6: The result for the pixel at linear index i is written on a single-cycle wr_en pulse. That pulse is visible two clock edges after the edge that accepts the strobe carrying pixel i+IMG_W+1, so the first IMG_W+1 strobes of a frame produce no writes.
- R7: After the strobe for the last pixel of a frame, the last IMG_W+1 results are written on consecutive cycles with no further strobes. The last strobe's own write and these form a run of IMG_W+2 consecutive write cycles.
- R8: Once a frame is complete, strobes are ignored and produce no writes until the next frame start.
- R9: A frame_start pulse discards the partial frame and any pending result. A pixel strobed in the same cycle is dropped, and the next strobe becomes pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a new frame and clears position and window state |
| pix_valid | input | 1 | Strobe: pix_data carries the next pixel |
| pix_data | input | 8 | Incoming pixel value |
| wr_en | output | 1 | One-cycle frame RAM write enable |
| wr_addr | output | $clog2(IMG_W*IMG_H) | Linear write address row*IMG_W+col |
| wr_data | output | 8 | Gradient magnitude, 0 at borders |

## Verification
The filter is driven with several whole frames:
- A flat field must give zero everywhere; this catches sign or weight errors that do not cancel.
- A vertical step saturates Gx alone, and a horizontal step produces 240 through Gy alone. Together they separate the two kernels and show which axis each one acts on.
- A horizontal ramp and a diagonal ramp give unsaturated sums of 80. The diagonal ramp shows that |Gx| and |Gy| are added rather than one of them being picked.
- An irregular pseudo-random field, strobed back to back, is compared with a bench model at every pixel. This exposes column or row misalignment between the line buffers and the window.

Frames strobed with gaps of one to three idle cycles are compared with the back-to-back frame to show that the idle cycles change nothing. Directed runs check single-pulse timing, the trailing flush, strobes after the end of a frame, and a restart in the middle of a frame.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    parameter int PIX_W   = 8;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0] pix_t;

    // 3x3 neighbourhood: index [row][col], row 0 is the oldest row,
    // col 2 is the most recently arrived column.
    typedef pix_t [2:0][2:0] win_t;

    // One column of three vertically adjacent pixels, [0] = top.
    typedef pix_t [2:0] col3_t;

    function automatic pix_t grad_mag(input win_t w);
        int gx;
        int gy;
        int s;
        gx = int'(w[0][2]) + 2 * int'(w[1][2]) + int'(w[2][2])
           - int'(w[0][0]) - 2 * int'(w[1][0]) - int'(w[2][0]);
        gy = int'(w[2][0]) + 2 * int'(w[2][1]) + int'(w[2][2])
           - int'(w[0][0]) - 2 * int'(w[0][1]) - int'(w[0][2]);
        if (gx < 0) gx = -gx;
        if (gy < 0) gy = -gy;
        s = gx + gy;
        if (s > PIX_MAX) s = PIX_MAX;
        return pix_t'(s);
    endfunction

endpackage

// File: rtl/sobel_linebuf.sv
module sobel_linebuf #(
    parameter int IMG_W = 8,
    localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
    input  logic                clk,
    input  logic                shift,
    input  logic [COL_W-1:0]    col,
    input  sobel_pkg::pix_t     din,
    output sobel_pkg::pix_t     dout
);
    import sobel_pkg::*;

    pix_t row_mem [IMG_W];

    // Read happens before the write of the same strobe, so dout is the
    // pixel one row above the incoming one.
    assign dout = row_mem[col];

    always_ff @(posedge clk) begin
        if (shift) begin
            row_mem[col] <= din;
        end
    end

endmodule

// File: rtl/sobel_window.sv
module sobel_window (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  sobel_pkg::col3_t  col_in,
    output sobel_pkg::win_t   win
);
    import sobel_pkg::*;

    for (genvar r = 0; r < 3; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                win[r] <= '0;
            end else if (shift) begin
                win[r][0] <= win[r][1];
                win[r][1] <= win[r][2];
                win[r][2] <= col_in[r];
            end
        end
    end

    // R2: the neighbourhood only moves on an accepted strobe
    a_r2_window_holds: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(win));

endmodule

// File: rtl/sobel_raster.sv
module sobel_raster #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
    localparam int ROW_W  = (IMG_H > 1) ? $clog2(IMG_H) : 1,
    localparam int ADDR_W = $clog2(IMG_W * IMG_H),
    localparam int FL_W   = $clog2(IMG_W + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               pix_valid,
    output logic               shift,
    output logic [COL_W-1:0]   col,
    output logic               s1_valid,
    output logic               s1_zero,
    output logic [ADDR_W-1:0]  s1_addr
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);
    localparam logic [ROW_W-1:0] ROW_ONE  = ROW_W'(1);
    localparam logic [ROW_W-1:0] ROW_TWO  = ROW_W'(2);
    localparam logic [FL_W-1:0]  FL_INIT  = FL_W'(IMG_W + 1);
    localparam logic [FL_W-1:0]  FL_ONE   = FL_W'(1);

    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic [ROW_W-1:0]  cen_row;
    logic [COL_W-1:0]  cen_col;
    logic [ADDR_W-1:0] cen_addr;
    logic              done;
    logic              flushing;
    logic [FL_W-1:0]   fl_left;

    logic accept;
    logic last_in;
    logic lag_ok;
    logic emit;
    logic cen_border;

    assign accept     = pix_valid && !done && !frame_start;
    assign last_in    = (in_row == ROW_LAST) && (in_col == COL_LAST);
    assign lag_ok     = (in_row >= ROW_TWO) || ((in_row == ROW_ONE) && (in_col != '0));
    assign emit       = (accept && lag_ok) || (flushing && fl_left != '0);
    assign cen_border = (cen_row == '0) || (cen_row == ROW_LAST)
                     || (cen_col == '0) || (cen_col == COL_LAST);

    assign shift = accept;
    assign col   = in_col;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            in_row   <= '0;
            in_col   <= '0;
            cen_row  <= '0;
            cen_col  <= '0;
            cen_addr <= '0;
            done     <= 1'b0;
            flushing <= 1'b0;
            fl_left  <= '0;
            s1_valid <= 1'b0;
            s1_zero  <= 1'b0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= emit;
            if (emit) begin
                s1_zero  <= cen_border;
                s1_addr  <= cen_addr;
                cen_addr <= cen_addr + 1'b1;
                if (cen_col == COL_LAST) begin
                    cen_col <= '0;
                    cen_row <= cen_row + 1'b1;
                end else begin
                    cen_col <= cen_col + 1'b1;
                end
            end
            if (accept) begin
                if (last_in) begin
                    in_row   <= '0;
                    in_col   <= '0;
                    done     <= 1'b1;
                    flushing <= 1'b1;
                    fl_left  <= FL_INIT;
                end else if (in_col == COL_LAST) begin
                    in_col <= '0;
                    in_row <= in_row + 1'b1;
                end else begin
                    in_col <= in_col + 1'b1;
                end
            end
            if (flushing && fl_left != '0) begin
                fl_left <= fl_left - 1'b1;
                if (fl_left == FL_ONE) flushing <= 1'b0;
            end
        end
    end

    // R7: while flushing, one result issues every cycle
    a_r7_flush_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (flushing && !frame_start) |=> s1_valid);

    // R8: a finished frame issues nothing more
    a_r8_quiet_after_frame: assert property (@(posedge clk) disable iff (rst)
        (done && !flushing && !frame_start) |=> !s1_valid);

    // R4: flush results are all border pixels
    a_r4_flush_is_border: assert property (@(posedge clk) disable iff (rst)
        (flushing && !frame_start) |=> s1_zero);

endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6,
    localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
    localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_start,
    input  logic                         pix_valid,
    input  logic [sobel_pkg::PIX_W-1:0]  pix_data,
    output logic                         wr_en,
    output logic [ADDR_W-1:0]            wr_addr,
    output logic [sobel_pkg::PIX_W-1:0]  wr_data
);
    import sobel_pkg::*;

    logic              shift;
    logic [COL_W-1:0]  col;
    logic              s1_valid;
    logic              s1_zero;
    logic [ADDR_W-1:0] s1_addr;
    win_t              win;
    col3_t             col_vec;
    pix_t              taps [3];

    sobel_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .shift       (shift),
        .col         (col),
        .s1_valid    (s1_valid),
        .s1_zero     (s1_zero),
        .s1_addr     (s1_addr)
    );

    // taps[0] = incoming row, taps[1] = one row up, taps[2] = two rows up
    assign taps[0] = pix_data;

    for (genvar g = 0; g < 2; g++) begin : g_line
        sobel_linebuf #(.IMG_W(IMG_W)) u_lb (
            .clk   (clk),
            .shift (shift),
            .col   (col),
            .din   (taps[g]),
            .dout  (taps[g+1])
        );
    end

    assign col_vec[0] = taps[2];
    assign col_vec[1] = taps[1];
    assign col_vec[2] = taps[0];

    sobel_window u_win (
        .clk    (clk),
        .rst    (rst),
        .clr    (frame_start),
        .shift  (shift),
        .col_in (col_vec),
        .win    (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= s1_valid;
            if (s1_valid) begin
                wr_addr <= s1_addr;
                wr_data <= s1_zero ? '0 : grad_mag(win);
            end
        end
    end

    // R4: top image row is always written as zero
    a_r4_top_row_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) < IMG_W) |-> (wr_data == '0));

    // R5: addresses stay inside the frame
    a_r5_addr_in_frame: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < IMG_W * IMG_H));

    // R6: each write follows an issued result of the previous cycle
    a_r6_write_follows_issue: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> wr_en);

endmodule

// File: tb/sobel_edge_stream_test.sv
`timescale 1ns/1ps
module sobel_edge_stream_test;

    localparam int W = 8;
    localparam int H = 6;
    localparam int N = W * H;
    localparam int AW = $clog2(N);

    // {pattern, row, col, expected, requirement}
    localparam int NT = 12;
    localparam int TBL [NT][5] = '{
        '{0, 2, 3,   0, 3},
        '{1, 2, 3, 255, 3},
        '{1, 2, 5,   0, 3},
        '{2, 2, 4, 240, 3},
        '{2, 3, 4, 240, 3},
        '{2, 4, 4,   0, 3},
        '{3, 3, 3,  80, 3},
        '{4, 2, 2,  80, 3},
        '{1, 2, 0,   0, 4},
        '{1, 0, 3,   0, 4},
        '{1, 5, 4,   0, 4},
        '{2, 2, 7,   0, 4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = '0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    int got  [N];
    int hits [N];
    int nwrites = 0;
    int order_err = 0;

    always #2.5 clk = ~clk;

    sobel_edge_stream #(.IMG_W(W), .IMG_H(H)) uut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (int'(wr_addr) != nwrites) order_err++;
            got[wr_addr]  = int'(wr_data);
            hits[wr_addr] = hits[wr_addr] + 1;
            nwrites++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pix_of(input int pat, input int r, input int c);
        case (pat)
            0: return 100;
            1: return (c < 4) ? 0 : 200;
            2: return (r < 3) ? 0 : 60;
            3: return 10 * c;
            4: return 5 * (r + c);
            default: return (r * 37 + c * 91 + r * c * 13) % 256;
        endcase
    endfunction

    function automatic int model(input int pat, input int r, input int c);
        int gx, gy, s;
        if (r == 0 || r == H - 1 || c == 0 || c == W - 1) return 0;
        gx = pix_of(pat, r-1, c+1) + 2*pix_of(pat, r, c+1) + pix_of(pat, r+1, c+1)
           - pix_of(pat, r-1, c-1) - 2*pix_of(pat, r, c-1) - pix_of(pat, r+1, c-1);
        gy = pix_of(pat, r+1, c-1) + 2*pix_of(pat, r+1, c) + pix_of(pat, r+1, c+1)
           - pix_of(pat, r-1, c-1) - 2*pix_of(pat, r-1, c) - pix_of(pat, r-1, c+1);
        if (gx < 0) gx = -gx;
        if (gy < 0) gy = -gy;
        s = gx + gy;
        return (s > 255) ? 255 : s;
    endfunction

    task automatic clear_capture();
        for (int i = 0; i < N; i++) begin
            got[i] = -1;
            hits[i] = 0;
        end
        nwrites = 0;
        order_err = 0;
    endtask

    task automatic start_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        clear_capture();
    endtask

    task automatic send_px(input int v, input int gap);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = 8'(v);
        @(negedge clk);
        pix_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Sends a frame; b2b selects back-to-back strobes. Checks the flush (R7).
    task automatic send_frame(input int pat, input bit b2b);
        int n_at_last;
        int run;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data  = 8'(pix_of(pat, k / W, k % W));
            if (!b2b) begin
                if (k != N - 1) begin
                    @(negedge clk);
                    pix_valid = 1'b0;
                    repeat (k % 3) @(negedge clk);
                end
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        #1;
        n_at_last = nwrites;
        run = 0;
        for (int i = 0; i < W + 2; i++) begin
            @(negedge clk);
            if (wr_en) run++;
        end
        check(n_at_last == N - W - 2, "R7 writes before last result", n_at_last, N - W - 2);
        check(run == W + 2, "R7 consecutive tail writes", run, W + 2);
        @(negedge clk);
        check(wr_en == 1'b0, "R7 tail ends", int'(wr_en), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input int pat);
        int bad_hits, bad_val, first_act, first_exp;
        bad_hits = 0;
        bad_val = 0;
        first_act = 0;
        first_exp = 0;
        for (int i = 0; i < N; i++) begin
            if (hits[i] != 1) bad_hits++;
            if (got[i] != model(pat, i / W, i % W)) begin
                if (bad_val == 0) begin
                    first_act = got[i];
                    first_exp = model(pat, i / W, i % W);
                end
                bad_val++;
            end
        end
        check(nwrites == N, "R5 writes per frame", nwrites, N);
        check(bad_hits == 0, "R5 each address once", bad_hits, 0);
        check(order_err == 0, "R5 raster address order", order_err, 0);
        check(bad_val == 0, "R3 frame matches model", first_act, first_exp);
    endtask

    initial begin
        clear_capture();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
        check(wr_addr == '0, "R1 wr_addr after reset", int'(wr_addr), 0);
        check(wr_data == '0, "R1 wr_data after reset", int'(wr_data), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Pattern table walk (R3 values, R4 borders); pattern 5 back-to-back (R2)
        for (int p = 0; p < 6; p++) begin
            start_frame();
            send_frame(p, p == 5);
            check_frame(p);
            for (int t = 0; t < NT; t++) begin
                if (TBL[t][0] == p) begin
                    int a;
                    a = TBL[t][1] * W + TBL[t][2];
                    if (TBL[t][4] == 3)
                        check(got[a] == TBL[t][3], "R3 table point", got[a], TBL[t][3]);
                    else
                        check(got[a] == TBL[t][3], "R4 border point", got[a], TBL[t][3]);
                end
            end
            if (p == 5) begin
                // R8: strobes after a complete frame are ignored
                for (int i = 0; i < 10; i++) send_px(200, 0);
                repeat (5) @(negedge clk);
                check(nwrites == N, "R8 no writes after frame end", nwrites, N);
                check(got[W + 1] == model(5, 1, 1), "R8 results untouched", got[W + 1], model(5, 1, 1));
            end
        end

        // R6: latency and single-cycle pulse
        start_frame();
        for (int k = 0; k <= W; k++) send_px(pix_of(5, k / W, k % W), 3);
        check(nwrites == 0, "R6 no write during first W+1 strobes", nwrites, 0);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = 8'(pix_of(5, 1, 1));
        @(negedge clk);
        pix_valid = 1'b0;
        check(wr_en == 1'b0, "R6 no write one edge after strobe", int'(wr_en), 0);
        @(negedge clk);
        check(wr_en == 1'b1 && wr_addr == '0, "R6 write two edges after strobe", int'(wr_en), 1);
        @(negedge clk);
        check(wr_en == 1'b0, "R6 single cycle pulse", int'(wr_en), 0);
        // R2: idle cycles produce nothing
        repeat (20) @(negedge clk);
        check(nwrites == 1, "R2 idle cycles write nothing", nwrites, 1);

        // R9: restart mid-frame with a strobe in the frame_start cycle
        @(negedge clk);
        frame_start = 1'b1;
        pix_valid   = 1'b1;
        pix_data    = 8'd250;
        @(negedge clk);
        frame_start = 1'b0;
        pix_valid   = 1'b0;
        clear_capture();
        send_frame(4, 1'b0);
        check(nwrites == N, "R9 restart gives full frame", nwrites, N);
        check(got[W + 1] == model(4, 1, 1), "R9 dropped strobe pixel", got[W + 1], model(4, 1, 1));
        check_frame(4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule